// File: doc/BRIEF.md
# External Interrupt Detector with Glitch Filter

This block watches four external interrupt pins and turns activity on them into one prioritised request for a processor core. Each pin first passes a two-flop synchroniser. The two low pins (line 0 and line 1) can fire on a rising edge, a falling edge, a high level or a low level. The two high pins (line 2 and line 3) can fire on a rising edge, a falling edge or on both edges. Line 3 also passes a digital glitch filter. This filter samples at a selectable fraction of the clock and changes its output only when two consecutive samples agree.

Edge events set a pending flag. The flag stays set until the core acknowledges the vector that was issued for it. A level request is not latched: it follows the synchronised pin while the line is enabled. The block presents the highest-priority active request, with line 0 highest, together with its one-byte vector. Detected edges on lines 2 and 3 also leave the block as one-cycle event strobes for a timer. The clock of this block is the instruction-cycle clock.

Top module: `ext_irq_ctrl`

## Requirements
- R1: While reset is held and in the cycle after it is released, `irq_o` is 0, `vec_o` is 0x00 and `tmr_evt_o` is 0.
- R2: Lines 0 and 1 take a 2-bit trigger code: 0 = rising edge, 1 = falling edge. In these modes an edge of the other polarity has no effect. A detected edge sets a pending flag, and the flag stays set until it is acknowledged.
- R3: For lines 0 and 1, code 2 requests while the pin is high and code 3 requests while it is low. The request follows the pin and ends when the pin leaves that level. `ack_i` does not end it.
- R4: Lines 2 and 3 take a 2-bit trigger code: 0 = rising edge, 1 = falling edge, 2 or 3 = both edges. Each detected edge sets the pending flag of that line.
- R5: The vector presented is 0x03 for line 0, 0x0B for line 1, 0x13 for line 2 and 0x1B for line 3. It is 0x00 when no request is active.
- R6: When several requests are active, the lowest-numbered line is presented. Asserting `ack_i` for one cycle clears only the pending flag of the line being presented at that time.
- R7: An edge that occurs while the enable bit of its line is 0 is discarded. Setting the enable bit afterwards does not raise a request.
- R8: The line-3 filter samples every cycle for rate code 0, every 16 cycles for code 1, and every 64 cycles for codes 2 and 3. A pulse of 2, 32 or 128 cycles respectively is accepted. A pulse shorter than one sample period is rejected.
- R9: Every detected edge on line 2 (bit 0) or line 3 (bit 1) gives a one-cycle pulse on `tmr_evt_o`, using the trigger code of that line. This happens whether or not the line is enabled.
- R10: On lines 0, 1 and 2, a pulse that lasts one clock cycle is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 4 | Raw interrupt pins, bit n is line n |
| trig_lo_i | input | 4 | Trigger codes: bits 1:0 for line 0, bits 3:2 for line 1 |
| trig_hi_i | input | 4 | Trigger codes: bits 1:0 for line 2, bits 3:2 for line 3 |
| irq_en_i | input | 4 | Per-line enable |
| flt_rate_i | input | 2 | Line-3 filter sample-rate code |
| ack_i | input | 1 | One-cycle acknowledge of the presented vector |
| irq_o | output | 1 | A request is active |
| vec_o | output | 8 | Vector of the presented request |
| tmr_evt_o | output | 2 | Timer event strobes from line 2 (bit 0) and line 3 (bit 1) |

## Verification
A stuck or lost pending flag shows up as a wrong vector or a missing request. It appears within four cycles of the pin change for lines 0 to 2, and within two filter sample periods for line 3. If the edge memory is corrupted, a polarity is detected falsely or not at all. This shows as an extra or missing timer strobe, which the bench counts edge by edge. A filter whose sample state is wrong either passes a glitch or drops a pulse. The bench probes this at the rejection and acceptance bounds of every rate.

// File: rtl/irq_pkg.sv
// Shared constants and types for the external interrupt detector.
// Assumes four lines; vectors are spaced evenly from a base byte.
package irq_pkg;

    localparam int unsigned NUM_LINES = 4;
    localparam int unsigned VEC_W     = 8;
    localparam logic [7:0]  VEC_BASE  = 8'h03;
    localparam logic [7:0]  VEC_STEP  = 8'h08;

    // Trigger code; the meaning of the two upper codes depends on line group
    typedef enum logic [1:0] {
        TRIG_RISE = 2'd0,
        TRIG_FALL = 2'd1,
        TRIG_ALT0 = 2'd2,
        TRIG_ALT1 = 2'd3
    } trig_t;

    // Vector byte of a line
    function automatic logic [VEC_W-1:0] vec_of(input int unsigned idx);
        logic [VEC_W-1:0] step_sum;
        step_sum = VEC_STEP * idx[VEC_W-1:0];
        return VEC_BASE + step_sum;
    endfunction

endpackage

// File: rtl/irq_sync.sv
// Multi-stage synchroniser for a bus of independent asynchronous bits.
// Assumes each bit is handled on its own; there is no bus coherency.
module irq_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // shift the raw pins through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/irq_glitch_filter.sv
// Sampled glitch filter. It takes a sample every 1, DIV_MID or DIV_SLOW cycles
// and moves its output only when two consecutive samples agree.
// Assumes a synchronised input.
module irq_glitch_filter #(
    parameter int unsigned DIV_MID  = 16,
    parameter int unsigned DIV_SLOW = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rate_i,
    input  logic       sig_i,
    output logic       sig_o
);

    localparam int unsigned CW = $clog2(DIV_SLOW) + 1;
    localparam logic [CW-1:0] LIM_MID  = CW'(DIV_MID - 1);
    localparam logic [CW-1:0] LIM_SLOW = CW'(DIV_SLOW - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;
    logic          tick;
    logic          samp_q;
    logic          filt_q;

    // pick the terminal count from the rate code
    always_comb begin
        case (rate_i)
            2'd0:    lim = '0;
            2'd1:    lim = LIM_MID;
            default: lim = LIM_SLOW;
        endcase
    end

    assign tick = (cnt_q >= lim);

    // free-running prescaler that produces the sample strobe
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    // take a sample on the strobe; follow it when two samples in a row agree
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= 1'b0;
            filt_q <= 1'b0;
        end else if (tick) begin
            samp_q <= sig_i;
            if (sig_i == samp_q) filt_q <= sig_i;
        end
    end

    assign sig_o = filt_q;

    // the filtered output may only move on a sample strobe
    assert_filt_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_q) |-> $past(tick))
        else $error("filter output moved off a sample strobe");

endmodule

// File: rtl/irq_detect.sv
// Edge/level detector for one line with a pending flag.
// LEVEL_OK=1 : codes 2/3 mean high/low level request (no latch).
// LEVEL_OK=0 : codes 2/3 mean both edges.
// Assumes a synchronised input; clr_i is the acknowledge for this line.
module irq_detect
    import irq_pkg::*;
#(
    parameter bit LEVEL_OK = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sig_i,
    input  logic [1:0] mode_i,
    input  logic       en_i,
    input  logic       clr_i,
    output logic       req_o,
    output logic       evt_o
);

    logic  prev_q;
    logic  flag_q;
    logic  evt_q;
    logic  rise, fall, edge_hit;
    logic  lvl_mode, lvl_match;
    trig_t mode;

    assign mode = trig_t'(mode_i);

    // decode the edge condition that applies to the selected code
    always_comb begin
        rise = sig_i & ~prev_q;
        fall = ~sig_i & prev_q;
        case (mode)
            TRIG_RISE: edge_hit = rise;
            TRIG_FALL: edge_hit = fall;
            default:   edge_hit = LEVEL_OK ? 1'b0 : (rise | fall);
        endcase
        lvl_mode  = LEVEL_OK && mode_i[1];
        lvl_match = mode_i[0] ? ~sig_i : sig_i;
    end

    // keep the previous input for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig_i;
    end

    // pending flag: setting wins over clearing; held clear in level mode
    always_ff @(posedge clk) begin
        if (!rst_n)                flag_q <= 1'b0;
        else if (lvl_mode)         flag_q <= 1'b0;
        else if (edge_hit && en_i) flag_q <= 1'b1;
        else if (clr_i)            flag_q <= 1'b0;
    end

    // one-cycle event strobe per detected edge, independent of enable
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= 1'b0;
        else        evt_q <= edge_hit;
    end

    assign req_o = en_i & (lvl_mode ? lvl_match : flag_q);
    assign evt_o = evt_q;

    // an unacknowledged edge flag stays set
    assert_flag_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i && !lvl_mode) |=> flag_q)
        else $error("pending flag dropped without acknowledge");

    // a strobe from an enabled line comes with its pending flag
    assert_evt_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q && $past(en_i)) |-> flag_q)
        else $error("event strobe without pending flag");

    generate
        if (LEVEL_OK) begin : g_lvl_chk
            // level mode never leaves a latched flag behind
            assert_lvl_noflag_R3: assert property (@(posedge clk) disable iff (!rst_n)
                lvl_mode |=> !flag_q)
                else $error("flag latched in level mode");
        end
    endgenerate

endmodule

// File: rtl/irq_prio.sv
// Fixed-priority selector: the lowest index wins. It drives the request,
// the vector and a one-hot grant that steers the acknowledge.
module irq_prio
    import irq_pkg::*;
#(
    parameter int unsigned N = NUM_LINES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req_i,
    output logic             irq_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [N-1:0]     grant_o
);

    // scan from the lowest priority upward so that index 0 wins last
    always_comb begin
        grant_o = '0;
        vec_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                grant_o = '0;
                grant_o[i] = 1'b1;
                vec_o   = vec_of(i);
            end
        end
        irq_o = |req_i;
    end

    assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o))
        else $error("more than one grant");

    assert_vec_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (vec_o == 8'h03 || vec_o == 8'h0B || vec_o == 8'h13 || vec_o == 8'h1B))
        else $error("illegal vector while requesting");

endmodule

// File: rtl/ext_irq_ctrl.sv
// External interrupt detector top. Four pins are synchronised; line 3 passes
// the glitch filter. Lines 0/1 allow level modes and lines 2/3 allow
// both-edge mode. Requests are prioritised and lines 2/3 drive timer strobes.
// Assumes clk is the instruction-cycle clock and ack_i is one cycle long.
module ext_irq_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DIV_MID     = 16,
    parameter int unsigned DIV_SLOW    = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] pin_i,
    input  logic [3:0] trig_lo_i,
    input  logic [3:0] trig_hi_i,
    input  logic [3:0] irq_en_i,
    input  logic [1:0] flt_rate_i,
    input  logic       ack_i,
    output logic       irq_o,
    output logic [7:0] vec_o,
    output logic [1:0] tmr_evt_o
);

    localparam int unsigned N = NUM_LINES;

    logic [N-1:0]   pin_s;
    logic [N-1:0]   line_sig;
    logic [N-1:0]   req_w;
    logic [N-1:0]   evt_w;
    logic [N-1:0]   grant_w;
    logic [2*N-1:0] trig_all;
    logic           int3_filt;

    assign trig_all = {trig_hi_i, trig_lo_i};

    irq_sync #(.WIDTH(N), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_s)
    );

    irq_glitch_filter #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .rate_i (flt_rate_i),
        .sig_i  (pin_s[N-1]),
        .sig_o  (int3_filt)
    );

    assign line_sig = {int3_filt, pin_s[N-2:0]};

    generate
        for (genvar i = 0; i < N; i++) begin : g_line
            irq_detect #(.LEVEL_OK(i < 2)) u_det (
                .clk    (clk),
                .rst_n  (rst_n),
                .sig_i  (line_sig[i]),
                .mode_i (trig_all[2*i +: 2]),
                .en_i   (irq_en_i[i]),
                .clr_i  (ack_i & grant_w[i]),
                .req_o  (req_w[i]),
                .evt_o  (evt_w[i])
            );

            // a strobe on a line held enabled, with an unchanged mode, means a request
            assert_evt_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (evt_w[i] && $past(irq_en_i[i]) && irq_en_i[i] && $stable(trig_all)) |-> irq_o)
                else $error("edge strobe on enabled line without request");
        end
    endgenerate

    irq_prio #(.N(N)) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_w),
        .irq_o   (irq_o),
        .vec_o   (vec_o),
        .grant_o (grant_w)
    );

    assign tmr_evt_o = evt_w[N-1:N-2];

endmodule

// File: tb/sim_ext_irq_ctrl.sv
module sim_ext_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] pin_i;
    logic [3:0] trig_lo_i;
    logic [3:0] trig_hi_i;
    logic [3:0] irq_en_i;
    logic [1:0] flt_rate_i;
    logic       ack_i;
    logic       irq_o;
    logic [7:0] vec_o;
    logic [1:0] tmr_evt_o;

    int checks = 0;
    int fails  = 0;
    int evt2_cnt = 0;
    int evt3_cnt = 0;

    always #4 clk = ~clk;   // 125 MHz

    ext_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .trig_lo_i(trig_lo_i),
        .trig_hi_i(trig_hi_i), .irq_en_i(irq_en_i), .flt_rate_i(flt_rate_i),
        .ack_i(ack_i), .irq_o(irq_o), .vec_o(vec_o), .tmr_evt_o(tmr_evt_o)
    );

    // count timer strobes edge by edge
    always @(posedge clk) begin
        if (rst_n && tmr_evt_o[0]) evt2_cnt++;
        if (rst_n && tmr_evt_o[1]) evt3_cnt++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_req(input string tag, input bit exp_irq, input int exp_vec);
        chk(irq_o == exp_irq, {tag, " irq"}, int'(irq_o), int'(exp_irq));
        chk(vec_o == exp_vec[7:0], {tag, " vec"}, int'(vec_o), exp_vec);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int idx, input int len);
        pin_i[idx] = 1'b1;
        wait_cyc(len);
        pin_i[idx] = 1'b0;
    endtask

    task automatic do_ack();
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; pin_i = '0; trig_lo_i = '0; trig_hi_i = '0;
        irq_en_i = '0; flt_rate_i = '0; ack_i = 1'b0;
        wait_cyc(4);
        chk_req("R1 in reset", 1'b0, 0);
        chk(tmr_evt_o == 2'b00, "R1 evt", int'(tmr_evt_o), 0);
        rst_n = 1'b1;
        wait_cyc(1);
        chk_req("R1 after release", 1'b0, 0);
    endtask

    task automatic t_prio();
        trig_lo_i = 4'b0000; trig_hi_i = 4'b0000; irq_en_i = 4'hF; flt_rate_i = 2'd0;
        pin_i = 4'hF; wait_cyc(3); pin_i = 4'h0;
        wait_cyc(8);
        chk_req("R5 R6 line0 first", 1'b1, 'h03);
        do_ack(); chk_req("R6 line1 next", 1'b1, 'h0B);
        do_ack(); chk_req("R6 line2 next", 1'b1, 'h13);
        do_ack(); chk_req("R5 line3 vector", 1'b1, 'h1B);
        do_ack(); chk_req("R6 all cleared", 1'b0, 0);
        irq_en_i = 4'h0;
    endtask

    task automatic t_edge01();
        trig_lo_i = 4'b0100; irq_en_i = 4'b0010;   // line1 falling
        pin_i[1] = 1'b1; wait_cyc(6);
        chk_req("R2 rising ignored in falling mode", 1'b0, 0);
        pin_i[1] = 1'b0; wait_cyc(6);
        chk_req("R2 falling latched", 1'b1, 'h0B);
        wait_cyc(10);
        chk_req("R2 flag held", 1'b1, 'h0B);
        do_ack();
        chk_req("R2 cleared by ack", 1'b0, 0);
        irq_en_i = 4'h0;
    endtask

    task automatic t_level();
        trig_lo_i = 4'b0010; irq_en_i = 4'b0001;   // line0 high level
        pin_i[0] = 1'b1; wait_cyc(5);
        chk_req("R3 high level request", 1'b1, 'h03);
        do_ack(); wait_cyc(2);
        chk_req("R3 ack no effect", 1'b1, 'h03);
        pin_i[0] = 1'b0; wait_cyc(5);
        chk_req("R3 request follows pin", 1'b0, 0);
        trig_lo_i = 4'b0011; wait_cyc(5);           // low level, pin low
        chk_req("R3 low level request", 1'b1, 'h03);
        pin_i[0] = 1'b1; wait_cyc(5);
        chk_req("R3 low level ends", 1'b0, 0);
        trig_lo_i = 4'b0000; wait_cyc(2);
        pin_i[0] = 1'b0; wait_cyc(5);
        irq_en_i = 4'h0;
    endtask

    task automatic t_enable();
        trig_lo_i = 4'b0000; irq_en_i = 4'b0000;
        pulse(0, 2); wait_cyc(6);
        chk_req("R7 disabled edge", 1'b0, 0);
        irq_en_i = 4'b0001; wait_cyc(3);
        chk_req("R7 not latched", 1'b0, 0);
        irq_en_i = 4'h0;
    endtask

    task automatic t_int2();
        trig_hi_i = 4'b0001; irq_en_i = 4'b0100;   // line2 falling
        pin_i[2] = 1'b1; wait_cyc(6);
        chk_req("R4 rising ignored", 1'b0, 0);
        pin_i[2] = 1'b0; wait_cyc(6);
        chk_req("R4 falling latched", 1'b1, 'h13);
        do_ack();
        trig_hi_i = 4'b0010;                        // both edges
        pin_i[2] = 1'b1; wait_cyc(6);
        chk_req("R4 both rising", 1'b1, 'h13);
        do_ack();
        chk_req("R4 ack", 1'b0, 0);
        pin_i[2] = 1'b0; wait_cyc(6);
        chk_req("R4 both falling", 1'b1, 'h13);
        do_ack();
        irq_en_i = 4'h0;
    endtask

    task automatic t_events();
        int e2, e3;
        irq_en_i = 4'h0; trig_hi_i = 4'b0010; flt_rate_i = 2'd0;  // line2 both, line3 rising
        e2 = evt2_cnt; e3 = evt3_cnt;
        pulse(2, 4); wait_cyc(8);
        chk(evt2_cnt - e2 == 2, "R9 line2 both edges", evt2_cnt - e2, 2);
        chk_req("R9 disabled no request", 1'b0, 0);
        pulse(3, 4); wait_cyc(10);
        chk(evt3_cnt - e3 == 1, "R9 line3 rising only", evt3_cnt - e3, 1);
        chk(evt2_cnt - e2 == 2, "R9 line2 unchanged", evt2_cnt - e2, 2);
    endtask

    task automatic t_short();
        trig_lo_i = 4'b0000; trig_hi_i = 4'b0000; irq_en_i = 4'b0110;
        pulse(1, 1); wait_cyc(6);
        chk_req("R10 one-cycle line1", 1'b1, 'h0B);
        do_ack();
        pulse(2, 1); wait_cyc(6);
        chk_req("R10 one-cycle line2", 1'b1, 'h13);
        do_ack();
        irq_en_i = 4'h0;
    endtask

    task automatic t_filter();
        trig_hi_i = 4'b0000; irq_en_i = 4'b1000;
        flt_rate_i = 2'd0;
        pulse(3, 1); wait_cyc(10);
        chk_req("R8 rate0 glitch rejected", 1'b0, 0);
        pulse(3, 2); wait_cyc(10);
        chk_req("R8 rate0 2-cycle accepted", 1'b1, 'h1B);
        do_ack();
        flt_rate_i = 2'd1; wait_cyc(20);
        pulse(3, 10); wait_cyc(60);
        chk_req("R8 rate1 short rejected", 1'b0, 0);
        pulse(3, 32); wait_cyc(60);
        chk_req("R8 rate1 32-cycle accepted", 1'b1, 'h1B);
        do_ack();
        flt_rate_i = 2'd2; wait_cyc(70);
        pulse(3, 40); wait_cyc(200);
        chk_req("R8 rate2 short rejected", 1'b0, 0);
        pulse(3, 128); wait_cyc(200);
        chk_req("R8 rate2 128-cycle accepted", 1'b1, 'h1B);
        do_ack();
        chk_req("R8 ack", 1'b0, 0);
        irq_en_i = 4'h0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_prio();
        t_edge01();
        t_level();
        t_enable();
        t_int2();
        t_events();
        t_short();
        t_filter();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule